// File: doc/BRIEF.md
# Lenient Predicated Select Unit

This block turns a two-armed conditional assignment into dataflow hardware. Given an operand pair `x` and `b`, it produces `y = -x` when `x` is strictly positive as a signed number, and `y = b*x` otherwise. Both arms start together on the accepted pair before the predicate is known. The negation arm and the comparator finish in one cycle. The multiply arm runs through a fixed pipeline of `MUL_LAT` stages.

The output stage is lenient. It raises its result as soon as the predicate and the arm the predicate picks have arrived. It does not wait for the slower arm that will be thrown away, so a positive `x` leaves before the product exists. The discarded product token is still collected before the unit takes a new pair. Tokens from different operand pairs therefore never meet in the selector.

Every value crosses the boundary as a data, valid and ack triple. A value moves on a rising edge where its valid and ack are both high. A producer holds its value until that edge.

Top module: `lps_select_unit`

## Requirements
- R1: The predicate is the signed test x > 0 on 32-bit two's complement `x`; x = 0 and every negative x take the product arm.
- R2: When the predicate is true, `y_data` is the 32-bit two's-complement negation of `x` (x = 0x7FFFFFFF gives 0x80000001).
- R3: When the predicate is false, `y_data` is the low 32 bits of the signed product b*x (0xFFFF0000 * 0x00010000 gives 0).
- R4: `x_ack` and `b_ack` are always equal. They are high only in a cycle where `x_vld` and `b_vld` are both high and no pair is in flight; a lone valid on one operand is never acknowledged.
- R5: Only one pair is in flight. With `y_ack` held high and operands always offered, consecutive input acks are MUL_LAT+1 = 4 cycles apart after a pair with x > 0, and MUL_LAT+2 = 5 cycles apart after a pair with x <= 0. No input ack occurs while `y_vld` is high, nor in the cycle right after an ack.
- R6: With the accept cycle counted as cycle 0, `y_vld` first rises in cycle 2 when x > 0, which is before the product is ready. It first rises in cycle MUL_LAT+1 = 4 when x <= 0.
- R7: While `y_vld` is high and `y_ack` is low, `y_vld` stays high and `y_data` keeps its value.
- R8: Driving `rst_n` low clears `y_vld` at once and holds both input acks low. After `rst_n` is released, the acks stay low through two more rising edges and may rise after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-edge synchronizer |
| x_vld | input | 1 | Operand x valid |
| x_data | input | W | Operand x, signed |
| x_ack | output | 1 | Operand x accepted |
| b_vld | input | 1 | Operand b valid |
| b_data | input | W | Operand b, signed |
| b_ack | output | 1 | Operand b accepted |
| y_vld | output | 1 | Result valid |
| y_data | output | W | Result |
| y_ack | input | 1 | Result accepted by consumer |

## Verification
A predicate latched wrongly, or an arm steered the wrong way, shows up on `y_data` at the first handshake of that pair: the negation and the product differ for every nonzero operand pair the bench uses. A selector that waits for both arms shows at the ports as `y_vld` arriving in cycle 4 instead of cycle 2 for a positive `x`. A selector that stops waiting for the discarded product lets the next input ack come early, so the gap between acks shrinks from 4 cycles. A broken hold register changes `y_data` during the first stalled cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    SEL_WAIT  = 2'd0,
    SEL_HOLD  = 2'd1,
    SEL_DRAIN = 2'd2
  } sel_state_e;

  function automatic logic is_pos(input logic sign_bit, input logic nonzero);
    return !sign_bit && nonzero;
  endfunction

endpackage

// File: rtl/lps_cmp_neg_arm.sv
module lps_cmp_neg_arm import lps_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         clr,
  input  logic [W-1:0] x,
  output logic         vld,
  output logic         pred,
  output logic [W-1:0] neg
);

  logic         vld_q, vld_d;
  logic         pred_q, pred_d;
  logic [W-1:0] neg_q, neg_d;

  always_comb begin
    vld_d  = vld_q;
    pred_d = pred_q;
    neg_d  = neg_q;
    if (clr) vld_d = 1'b0;
    if (start) begin
      vld_d  = 1'b1;
      pred_d = is_pos(x[W-1], |x);
      neg_d  = -x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      pred_q <= pred_d;
      neg_q  <= neg_d;
    end
  end

  assign vld  = vld_q;
  assign pred = pred_q;
  assign neg  = neg_q;

endmodule

// File: rtl/lps_mul_arm.sv
module lps_mul_arm #(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         clr,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         vld,
  output logic [W-1:0] prod
);

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    logic         in_v;
    logic [W-1:0] in_d;
    logic         v_q, v_d;
    logic [W-1:0] d_q;

    if (i == 0) begin : g_first
      assign in_v = start;
      assign in_d = a * b;
    end else begin : g_next
      assign in_v = g_stg[i-1].v_q;
      assign in_d = g_stg[i-1].d_q;
    end

    if (i == LAT-1) begin : g_last
      always_comb v_d = clr ? 1'b0 : (in_v | v_q);
    end else begin : g_pass
      always_comb v_d = in_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (in_v) d_q <= in_d;
    end
  end

  assign vld  = g_stg[LAT-1].v_q;
  assign prod = g_stg[LAT-1].d_q;

endmodule

// File: rtl/lps_lenient_sel.sv
module lps_lenient_sel import lps_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         p_vld,
  input  logic         p_val,
  input  logic [W-1:0] t_data,
  input  logic         f_vld,
  input  logic [W-1:0] f_data,
  input  logic         y_ack,
  output logic         y_vld,
  output logic [W-1:0] y_data,
  output logic         consume
);

  sel_state_e   state_q, state_d;
  logic [W-1:0] yd_q, yd_d;
  logic         load;

  always_comb begin
    state_d = state_q;
    yd_d    = yd_q;
    load    = 1'b0;
    consume = 1'b0;
    case (state_q)
      SEL_WAIT: begin
        if (p_vld && (p_val || f_vld)) begin
          load    = 1'b1;
          yd_d    = p_val ? t_data : f_data;
          state_d = SEL_HOLD;
        end
      end
      SEL_HOLD: begin
        if (y_ack) begin
          if (p_vld && f_vld) begin
            consume = 1'b1;
            state_d = SEL_WAIT;
          end else begin
            state_d = SEL_DRAIN;
          end
        end
      end
      SEL_DRAIN: begin
        if (p_vld && f_vld) begin
          consume = 1'b1;
          state_d = SEL_WAIT;
        end
      end
      default: state_d = SEL_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEL_WAIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load) yd_q <= yd_d;
  end

  assign y_vld  = (state_q == SEL_HOLD);
  assign y_data = yd_q;

endmodule

// File: rtl/lps_select_unit.sv
module lps_select_unit #(
  parameter int W       = 32,
  parameter int MUL_LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         x_vld,
  input  logic [W-1:0] x_data,
  output logic         x_ack,
  input  logic         b_vld,
  input  logic [W-1:0] b_data,
  output logic         b_ack,
  output logic         y_vld,
  output logic [W-1:0] y_data,
  input  logic         y_ack
);

  logic [1:0]   rs_q;
  logic         run;
  logic         busy_q, busy_d;
  logic         take, consume;
  logic         cn_vld, cn_pred;
  logic [W-1:0] cn_neg;
  logic         mu_vld;
  logic [W-1:0] mu_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign run = rs_q[1];

  assign take = run && !busy_q && x_vld && b_vld;

  always_comb begin
    busy_d = busy_q;
    if (consume) busy_d = 1'b0;
    if (take)    busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  lps_cmp_neg_arm #(.W(W)) u_cn (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .clr   (consume),
    .x     (x_data),
    .vld   (cn_vld),
    .pred  (cn_pred),
    .neg   (cn_neg)
  );

  lps_mul_arm #(.W(W), .LAT(MUL_LAT)) u_mu (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .clr   (consume),
    .a     (x_data),
    .b     (b_data),
    .vld   (mu_vld),
    .prod  (mu_prod)
  );

  lps_lenient_sel #(.W(W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .p_vld   (cn_vld),
    .p_val   (cn_pred),
    .t_data  (cn_neg),
    .f_vld   (mu_vld),
    .f_data  (mu_prod),
    .y_ack   (y_ack),
    .y_vld   (y_vld),
    .y_data  (y_data),
    .consume (consume)
  );

  assign x_ack = take;
  assign b_ack = take;

endmodule

// File: rtl/lps_select_chk.sv
module lps_select_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         x_vld,
  input logic         b_vld,
  input logic         x_ack,
  input logic         b_ack,
  input logic [W-1:0] x_data,
  input logic         y_vld,
  input logic         y_ack,
  input logic [W-1:0] y_data
);

  logic x_pos;
  assign x_pos = !x_data[W-1] && (|x_data);

  AST_ACK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    x_ack == b_ack); // R4
  AST_ACK_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    x_ack |-> (x_vld && b_vld)); // R4
  AST_NO_ACK_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> !x_ack); // R5
  AST_ACK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    x_ack |=> !x_ack); // R5
  AST_POS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (x_ack && x_pos) |-> ##2 y_vld); // R6
  AST_NONPOS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (x_ack && !x_pos) |-> ##2 !y_vld); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (y_vld && !y_ack) |=> (y_vld && $stable(y_data))); // R7

endmodule

bind lps_select_unit lps_select_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .x_vld  (x_vld),
  .b_vld  (b_vld),
  .x_ack  (x_ack),
  .b_ack  (b_ack),
  .x_data (x_data),
  .y_vld  (y_vld),
  .y_ack  (y_ack),
  .y_data (y_data)
);

// File: tb/sim_lps_select_unit.sv
module sim_lps_select_unit;

  localparam int W = 32;
  localparam int MUL_LAT = 3;
  localparam int NV = 8;
  localparam logic [W-1:0] TX [NV] = '{32'd5, 32'd0, 32'hFFFFFFFF, 32'h7FFFFFFF,
                                       32'hFFFF0000, 32'h80000000, 32'hFFFFFFF9, 32'd1};
  localparam logic [W-1:0] TB [NV] = '{32'd7, 32'd9, 32'd3, 32'd2,
                                       32'h00010000, 32'd3, 32'hFFFFFFFA, 32'd100};

  logic         clk, rst_n;
  logic         x_vld, b_vld, y_ack;
  logic [W-1:0] x_data, b_data;
  logic         x_ack, b_ack, y_vld;
  logic [W-1:0] y_data;
  int           cyc, n_chk, n_bad;

  lps_select_unit #(.W(W), .MUL_LAT(MUL_LAT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .x_vld(x_vld), .x_data(x_data), .x_ack(x_ack),
    .b_vld(b_vld), .b_data(b_data), .b_ack(b_ack),
    .y_vld(y_vld), .y_data(y_data), .y_ack(y_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] model(input logic [W-1:0] xv, input logic [W-1:0] bv);
    if ($signed(xv) > 0) return -xv;
    return xv * bv;
  endfunction

  task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one operand pair in, one result out; returns result and latency
  task automatic xfer(input logic [W-1:0] xv, input logic [W-1:0] bv, input int gap,
                      input int stall, output logic [W-1:0] yv, output int lat);
    int t0;
    logic held;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    x_vld = 1'b1; b_vld = 1'b1; x_data = xv; b_data = bv;
    #1;
    while (!x_ack) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    x_vld = 1'b0; b_vld = 1'b0;
    while (!y_vld) @(negedge clk);
    lat = cyc - t0;
    yv = y_data;
    held = 1'b1;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      if (!y_vld || y_data !== yv) held = 1'b0;
    end
    if (stall > 0) check(held, "R7 hold under stall", y_data, yv);
    y_ack = 1'b1;
    @(negedge clk);
    y_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] yv, xr, br;
    int lat, t0, t1, t2;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; x_vld = 1'b1; b_vld = 1'b1; y_ack = 1'b0;
    x_data = 32'd3; b_data = 32'd4;

    // R8: reset holds acks and output low, then two-edge release
    repeat (3) @(negedge clk);
    check(!x_ack && !b_ack && !y_vld, "R8 quiet in reset", {31'd0, x_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!x_ack, "R8 ack low after first edge", {31'd0, x_ack}, 0);
    @(negedge clk);
    check(x_ack && b_ack, "R8 ack after second edge", {31'd0, x_ack}, 1);
    @(negedge clk);
    x_vld = 1'b0; b_vld = 1'b0;
    while (!y_vld) @(negedge clk);
    check(y_data == model(32'd3, 32'd4), "R2 first pair", y_data, model(32'd3, 32'd4));
    y_ack = 1'b1; @(negedge clk); y_ack = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R7: table walk with output stalls
    for (int i = 0; i < NV; i++) begin
      xfer(TX[i], TB[i], i % 2, i % 3, yv, lat);
      check(yv == model(TX[i], TB[i]),
            ($signed(TX[i]) > 0) ? "R2 negate arm" : "R3 product arm (R1 select)",
            yv, model(TX[i], TB[i]));
    end

    // R6: lenient latency, positive vs non-positive
    xfer(32'd11, 32'd2, 0, 0, yv, lat);
    check(lat == 2, "R6 positive latency", lat, 2);
    xfer(32'd0, 32'd2, 0, 0, yv, lat);
    check(lat == MUL_LAT + 1, "R6 non-positive latency", lat, MUL_LAT + 1);
    check(yv == 32'd0, "R1 zero takes product", yv, 0);
    xfer(32'hFFFFFFFE, 32'd5, 0, 0, yv, lat);
    check(lat == MUL_LAT + 1, "R6 negative latency", lat, MUL_LAT + 1);
    repeat (6) @(negedge clk);

    // R4: a lone valid is never acknowledged
    x_vld = 1'b1; x_data = 32'd9;
    repeat (4) @(negedge clk);
    check(!x_ack && !b_ack && !y_vld, "R4 lone x ignored", {31'd0, x_ack}, 0);
    x_vld = 1'b0; b_vld = 1'b1; b_data = 32'd9;
    repeat (4) @(negedge clk);
    check(!x_ack && !b_ack && !y_vld, "R4 lone b ignored", {31'd0, b_ack}, 0);
    b_vld = 1'b0;
    repeat (2) @(negedge clk);

    // R5: ack spacing with output always accepted
    y_ack = 1'b1;
    x_vld = 1'b1; b_vld = 1'b1; x_data = 32'd6; b_data = 32'd2;
    #1;
    while (!x_ack) @(negedge clk);
    t0 = cyc;
    @(negedge clk); x_data = 32'hFFFFFFFD; #1;
    while (!x_ack) @(negedge clk);
    t1 = cyc;
    @(negedge clk); x_data = 32'd8; #1;
    while (!x_ack) @(negedge clk);
    t2 = cyc;
    @(negedge clk); x_vld = 1'b0; b_vld = 1'b0;
    check(t1 - t0 == MUL_LAT + 1, "R5 gap after positive", t1 - t0, MUL_LAT + 1);
    check(t2 - t1 == MUL_LAT + 2, "R5 gap after non-positive", t2 - t1, MUL_LAT + 2);
    repeat (8) @(negedge clk);
    y_ack = 1'b0;

    // random pairs with random input gaps and output stalls
    for (int k = 0; k < 40; k++) begin
      xr = $urandom();
      br = $urandom();
      if (k % 4 == 0) xr = xr >> 20;
      xfer(xr, br, int'($urandom() % 3), int'($urandom() % 4), yv, lat);
      check(yv == model(xr, br), "R2/R3 random pair", yv, model(xr, br));
    end

    // R8: reset during a held output
    @(negedge clk);
    x_vld = 1'b1; b_vld = 1'b1; x_data = 32'd4; b_data = 32'd1;
    #1;
    while (!x_ack) @(negedge clk);
    @(negedge clk); x_vld = 1'b0; b_vld = 1'b0;
    while (!y_vld) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!y_vld, "R8 reset clears output", {31'd0, y_vld}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(32'd2, 32'd3, 0, 0, yv, lat);
    check(yv == 32'hFFFFFFFE, "R2 after reset", yv, 32'hFFFFFFFE);

    summary();
    $finish;
  end

endmodule